// File: doc/BRIEF.md
# Multi-Mode Threshold Trigger Detector

This block compares a stream of signed samples from one converter channel against two programmable limits, a high limit and a low limit. It can also watch one external digital line. It drives a single level output that tells a separate acquisition controller when the selected condition holds. The block never starts a conversion itself. The controller polls the output and issues the acquisition on its own.

A configuration write loads a mode code and both limits in one cycle. The write also clears the output and any hysteresis arming. There are three kinds of mode:

- **Level modes** report below-low, above-high or strictly-inside-window.
- **Hysteresis modes** must first see the signal beyond the opposite limit before they assert. After that, they release only on that opposite crossing.
- **Digital mode** reports the synchronized external line.

Top module: `thresh_trigger`

## Requirements
- R1: After reset, `trig_out` is low, the mode is disabled, both limits are zero and no hysteresis arming is held.
- R2: In mode code 0 (disabled) and in the unused code 7, `trig_out` is low on every cycle, whatever the samples or the digital line do.
- R3: In mode code 1 (below-low), a valid sample strictly less than the low limit sets `trig_out`, and any other valid sample clears it.
- R4: In mode code 2 (above-high), a valid sample strictly greater than the high limit sets `trig_out`, and any other valid sample clears it.
- R5: In mode code 3 (inside), a valid sample with low < sample < high sets `trig_out`, and any other valid sample clears it. A sample equal to either limit is outside. When low >= high, the output never asserts.
- R6: In mode code 4 (falling hysteresis), `trig_out` asserts on a valid sample below low only after an earlier valid sample above high armed it. Once asserted, it stays high until a valid sample above high, which clears it and re-arms.
- R7: In mode code 5 (rising hysteresis), `trig_out` asserts on a valid sample above high only after an earlier valid sample below low armed it. Once asserted, it stays high until a valid sample below low, which clears it and re-arms.
- R8: In mode code 6 (digital), `trig_out` follows `din_pin` through a two-flop synchronizer and one output register. A change on `din_pin` before edge k shows after edge k+2. Samples have no effect in this mode.
- R9: A cycle with `cfg_wr` high clears `trig_out` and the hysteresis arming at that edge. This takes precedence over a valid sample in the same cycle, so a hysteresis mode needs a new arming crossing after each write.
- R10: Samples and limits are two's complement. In the analog modes (codes 1 to 5), `trig_out` changes only at the edge that takes a valid sample. This gives one cycle of latency, and the output holds while `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code (0 to 6) |
| cfg_hi | input | SAMPLE_W | High limit, signed |
| cfg_lo | input | SAMPLE_W | Low limit, signed |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Sample, signed |
| din_pin | input | 1 | Asynchronous external digital line |
| trig_out | output | 1 | Registered trigger level |

## Verification
The embedded assertions check the following on every cycle:

- Disabled mode stays silent.
- A configuration write clears the output.
- The output holds in the analog modes while no sample arrives.
- An unarmed hysteresis mode cannot fire.
- The level modes and the digital mode track their inputs one edge later.

Only the bench's scenarios can show the following:

- Strictness at exactly the limits.
- The full arm, fire, hold and release sequences of both hysteresis modes.
- Re-arming after a reconfiguration.
- The empty window when low exceeds high.
- The exact three-edge latency of the digital path.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_BELOW   = 3'd1,
        MODE_ABOVE   = 3'd2,
        MODE_INSIDE  = 3'd3,
        MODE_HYST_LO = 3'd4,
        MODE_HYST_HI = 3'd5,
        MODE_DIGITAL = 3'd6,
        MODE_RSVD    = 3'd7
    } trig_mode_e;

    typedef struct packed {
        logic armed;
        logic trig;
    } eval_st_t;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [2:0]                 cfg_mode,
    input  logic signed [SAMPLE_W-1:0] cfg_hi,
    input  logic signed [SAMPLE_W-1:0] cfg_lo,
    output trig_mode_e                 mode,
    output logic signed [SAMPLE_W-1:0] hi_lim,
    output logic signed [SAMPLE_W-1:0] lo_lim
);
    typedef struct packed {
        trig_mode_e                 mode;
        logic signed [SAMPLE_W-1:0] hi;
        logic signed [SAMPLE_W-1:0] lo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.mode = trig_mode_e'(cfg_mode);
            cfg_d.hi   = cfg_hi;
            cfg_d.lo   = cfg_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_OFF, hi: '0, lo: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode   = cfg_q.mode;
    assign hi_lim = cfg_q.hi;
    assign lo_lim = cfg_q.lo;
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_in;
        end else begin : g_chain
            always_comb sh_d = {sh_q[LAST-1:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[LAST];
endmodule

// File: rtl/trig_compare.sv
module trig_compare #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [SAMPLE_W-1:0] hi_lim,
    input  logic signed [SAMPLE_W-1:0] lo_lim,
    output logic                       below_lo,
    output logic                       above_hi,
    output logic                       in_window
);
    always_comb begin
        below_lo  = sample < lo_lim;
        above_hi  = sample > hi_lim;
        in_window = (sample > lo_lim) && (sample < hi_lim);
    end
endmodule

// File: rtl/trig_eval.sv
module trig_eval
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  trig_mode_e mode,
    input  logic       smp_valid,
    input  logic       below_lo,
    input  logic       above_hi,
    input  logic       in_window,
    input  logic       din_s,
    output logic       trig
);
    eval_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.trig  = 1'b0;
            st_d.armed = 1'b0;
        end else begin
            unique case (mode)
                MODE_BELOW: begin
                    st_d.armed = 1'b0;
                    if (smp_valid) st_d.trig = below_lo;
                end
                MODE_ABOVE: begin
                    st_d.armed = 1'b0;
                    if (smp_valid) st_d.trig = above_hi;
                end
                MODE_INSIDE: begin
                    st_d.armed = 1'b0;
                    if (smp_valid) st_d.trig = in_window;
                end
                MODE_HYST_LO: begin
                    if (smp_valid) begin
                        if (st_q.trig) begin
                            if (above_hi) begin
                                st_d.trig  = 1'b0;
                                st_d.armed = 1'b1;
                            end
                        end else if (above_hi) begin
                            st_d.armed = 1'b1;
                        end else if (st_q.armed && below_lo) begin
                            st_d.trig  = 1'b1;
                            st_d.armed = 1'b0;
                        end
                    end
                end
                MODE_HYST_HI: begin
                    if (smp_valid) begin
                        if (st_q.trig) begin
                            if (below_lo) begin
                                st_d.trig  = 1'b0;
                                st_d.armed = 1'b1;
                            end
                        end else if (below_lo) begin
                            st_d.armed = 1'b1;
                        end else if (st_q.armed && above_hi) begin
                            st_d.trig  = 1'b1;
                            st_d.armed = 1'b0;
                        end
                    end
                end
                MODE_DIGITAL: begin
                    st_d.armed = 1'b0;
                    st_d.trig  = din_s;
                end
                default: begin
                    st_d.armed = 1'b0;
                    st_d.trig  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, trig: 1'b0};
        else        st_q <= st_d;
    end

    assign trig = st_q.trig;

    logic analog_mode;
    assign analog_mode = (mode == MODE_BELOW) || (mode == MODE_ABOVE) || (mode == MODE_INSIDE)
                      || (mode == MODE_HYST_LO) || (mode == MODE_HYST_HI);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF || mode == MODE_RSVD) |=> !trig); // R2
    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!trig && !st_q.armed)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_mode && !smp_valid && !cfg_wr) |=> $stable(trig)); // R10
    AST_HLO_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HYST_LO && !trig && !st_q.armed && !cfg_wr) |=> !trig); // R6
    AST_HHI_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HYST_HI && !trig && !st_q.armed && !cfg_wr) |=> !trig); // R7
    AST_BELOW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BELOW && smp_valid && !cfg_wr) |=> (trig == $past(below_lo))); // R3
    AST_ABOVE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ABOVE && smp_valid && !cfg_wr) |=> (trig == $past(above_hi))); // R4
    AST_DIG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIGITAL && !cfg_wr) |=> (trig == $past(din_s))); // R8
endmodule

// File: rtl/thresh_trigger.sv
module thresh_trigger
    import trig_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [2:0]                 cfg_mode,
    input  logic signed [SAMPLE_W-1:0] cfg_hi,
    input  logic signed [SAMPLE_W-1:0] cfg_lo,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       din_pin,
    output logic                       trig_out
);
    trig_mode_e                 mode;
    logic signed [SAMPLE_W-1:0] hi_lim, lo_lim;
    logic                       below_lo, above_hi, in_window, din_s;

    trig_cfg_regs #(.SAMPLE_W(SAMPLE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
        .mode(mode), .hi_lim(hi_lim), .lo_lim(lo_lim)
    );

    trig_compare #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .sample(smp_data), .hi_lim(hi_lim), .lo_lim(lo_lim),
        .below_lo(below_lo), .above_hi(above_hi), .in_window(in_window)
    );

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(din_pin), .sync_out(din_s)
    );

    trig_eval u_eval (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .mode(mode),
        .smp_valid(smp_valid), .below_lo(below_lo), .above_hi(above_hi),
        .in_window(in_window), .din_s(din_s), .trig(trig_out)
    );

    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INSIDE && lo_lim >= hi_lim && !cfg_wr) |=> !trig_out); // R5
endmodule

// File: tb/tb_thresh_trigger.sv
module tb_thresh_trigger;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic signed [W-1:0] cfg_hi = '0, cfg_lo = '0, smp_data = '0;
    logic smp_valid = 1'b0, din_pin = 1'b0;
    logic trig_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thresh_trigger #(.SAMPLE_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .smp_valid(smp_valid),
        .smp_data(smp_data), .din_pin(din_pin), .trig_out(trig_out)
    );

    typedef struct packed {
        logic               wr;
        logic [2:0]         mode;
        logic signed [15:0] hi;
        logic signed [15:0] lo;
        logic               vld;
        logic signed [15:0] smp;
        logic               exp;
        logic [3:0]         req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // R9 cfg below-low
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd150, 1'b1, 4'd3},  // R3
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd100, 1'b0, 4'd3},  // R3 strict
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b0, -16'sd200, 1'b0, 4'd10}, // R10 no valid
        '{1'b1, 3'd2,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // cfg above-high
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd101, 1'b1, 4'd4},  // R4
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd100, 1'b0, 4'd4},  // R4 strict
        '{1'b1, 3'd3,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // cfg inside
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd0,   1'b1, 4'd5},  // R5
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd100, 1'b0, 4'd5},  // R5 edge hi
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd99,  1'b1, 4'd5},  // R5
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd100, 1'b0, 4'd5},  // R5 edge lo
        '{1'b1, 3'd4,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // cfg falling hyst
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd150, 1'b0, 4'd6},  // R6 unarmed
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd150, 1'b0, 4'd6},  // R6 arm
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd0,   1'b0, 4'd6},
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd101, 1'b1, 4'd6},  // R6 fire
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd0,   1'b1, 4'd6},  // R6 hold
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd200, 1'b1, 4'd6},
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd101, 1'b0, 4'd6},  // R6 release
        '{1'b1, 3'd5,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // cfg rising hyst
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd150, 1'b0, 4'd7},  // R7 unarmed
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd150, 1'b0, 4'd7},  // R7 arm
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd101, 1'b1, 4'd7},  // R7 fire
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd50,  1'b1, 4'd7},  // R7 hold
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd101, 1'b0, 4'd7},  // R7 release
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd200, 1'b1, 4'd7},  // R7 re-armed
        '{1'b1, 3'd5,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // R9 rewrite
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd200, 1'b0, 4'd9},  // R9 needs new arm
        '{1'b1, 3'd3, -16'sd10,   16'sd10,  1'b0,  16'sd0,   1'b0, 4'd9},  // inverted window
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1,  16'sd0,   1'b0, 4'd5},  // R5 empty
        '{1'b1, 3'd0,  16'sd100, -16'sd100, 1'b0,  16'sd0,   1'b0, 4'd9},  // cfg off
        '{1'b0, 3'd0,  16'sd0,    16'sd0,   1'b1, -16'sd500, 1'b0, 4'd2}   // R2
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (trig_out !== exp) begin
            failures++;
            $display("FAIL %s: trig_out=%b expected=%b at %0t", req, trig_out, exp, $time);
        end
    endtask

    task automatic drive(input logic wr, input logic [2:0] m,
                         input logic signed [W-1:0] hi, input logic signed [W-1:0] lo,
                         input logic vld, input logic signed [W-1:0] s);
        cfg_wr = wr; cfg_mode = m; cfg_hi = hi; cfg_lo = lo;
        smp_valid = vld; smp_data = s;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: trig_out=%b expected=done", trig_out);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].mode, VEC[i].hi, VEC[i].lo, VEC[i].vld, VEC[i].smp);
            @(negedge clk);
            check(VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R8 digital: din change before edge k visible after edge k+2
        drive(1'b1, 3'd6, 16'sd100, -16'sd100, 1'b0, 16'sd0);
        @(negedge clk);
        drive(1'b0, 3'd0, 16'sd0, 16'sd0, 1'b1, -16'sd900);
        din_pin = 1'b1;
        @(negedge clk); check(1'b0, "R8 stage1");
        @(negedge clk); check(1'b0, "R8 stage2");
        @(negedge clk); check(1'b1, "R8 high");
        smp_data = 16'sd900;
        din_pin = 1'b0;
        @(negedge clk); check(1'b1, "R8 hold1");
        @(negedge clk); check(1'b1, "R8 hold2");
        @(negedge clk); check(1'b0, "R8 low");

        // R2 reserved code 7 ignores din and samples
        drive(1'b1, 3'd7, 16'sd100, -16'sd100, 1'b0, 16'sd0);
        din_pin = 1'b1;
        @(negedge clk);
        drive(1'b0, 3'd0, 16'sd0, 16'sd0, 1'b1, -16'sd500);
        repeat (4) @(negedge clk);
        check(1'b0, "R2 code7");
        din_pin = 1'b0;

        // R9 write wins over simultaneous valid sample
        drive(1'b1, 3'd1, 16'sd100, -16'sd100, 1'b0, 16'sd0);
        @(negedge clk);
        drive(1'b0, 3'd0, 16'sd0, 16'sd0, 1'b1, -16'sd300);
        @(negedge clk); check(1'b1, "R3 pre");
        drive(1'b1, 3'd1, 16'sd100, -16'sd100, 1'b1, -16'sd300);
        @(negedge clk); check(1'b0, "R9 precedence");
        drive(1'b0, 3'd0, 16'sd0, 16'sd0, 1'b1, -16'sd300);
        @(negedge clk); check(1'b1, "R10 latency");

        // R10 extreme signed values
        drive(1'b1, 3'd2, 16'sd32766, -16'sd32768, 1'b0, 16'sd0);
        @(negedge clk);
        drive(1'b0, 3'd0, 16'sd0, 16'sd0, 1'b1, 16'sd32767);
        @(negedge clk); check(1'b1, "R4 max");
        smp_data = -16'sd32768;
        @(negedge clk); check(1'b0, "R10 signed");

        // R1 mid-run reset
        rst_n = 1'b0;
        @(negedge clk); check(1'b0, "R1 reset");
        rst_n = 1'b1;
        smp_data = 16'sd32767;
        @(negedge clk); check(1'b0, "R1 mode off");

        done = 1'b1;
        finish_run();
    end
endmodule